// File: doc/BRIEF.md
# Byte-Port DMA Channel Register Bank

This block is the software-facing register bank of a small multi-channel DMA controller. A processor programs it over an 8-bit I/O port. Each channel keeps a transfer mode, an auto-reload flag, a mask bit, and a base and a current copy of a 16-bit memory address and a 16-bit cycle count. Every 16-bit register sits behind one byte-wide port location. A single shared byte pointer decides whether an access reaches the low byte or the high byte. The pointer flips after each such access, so software clears it with a command before it programs or reads a register.

A device raises a request line for its channel. The bank forwards that request only while the channel is unmasked. Each acknowledge strobe stands in for one bus cycle: the channel presents its current address and direction on a registered bus output, then moves its address up by one and its count down by one. When the count runs out, the channel raises a terminal-count pulse and latches a status bit that clears when it is read. It then either masks itself or reloads its base values. A channel in hand-off (cascade) mode passes its request through but never makes cycles of its own. One parameter builds the channels as word-wide, and in that case the bus address is a byte address, twice the word address.

Top module: `dma_regs_front`

## Requirements
- R1: After a synchronous reset, every channel is masked, the read data output is 0, the byte pointer is clear, the status flags are 0 and no bus cycle is signalled.
- R2: Port addresses 2c and 2c+1 give the address and the count registers of channel c. An access to either one reaches the low byte when the byte pointer is clear and the high byte when it is set. The pointer toggles after every read or write of a channel register.
- R3: A write of any value to port address 10 clears the byte pointer, so that the next channel-register access reaches the low byte.
- R4: Writing a byte of the address or count register loads both the base copy and the current copy. Reads return the current copy.
- R5: A masked channel ignores acknowledges and does not forward its request. An unmasked channel drives its ch_req bit one cycle after its request input. Writing to port address 9 with bits[1:0] holding the channel number and bit 2 holding the new mask value sets or clears one mask bit.
- R6: Each acknowledge of an unmasked channel that is not in hand-off mode raises bus_valid for one cycle, with bus_addr set to the address before the step. It then adds one to the current address and subtracts one from the current count.
- R7: The acknowledge that moves the count from 1 to 0 pulses that channel's tc_pulse bit and sets its status bit. Port address 8 returns the status bits, one per channel, and the read clears them. The count reads back as 0 afterwards. Unless auto-reload is set, the channel masks itself.
- R8: A write to port address 8 sets the mode of the channel given in bits[1:0]: bits[3:2] hold the mode (00 device-to-memory, 01 memory-to-device, 1x hand-off) and bit 4 sets auto-reload. With auto-reload set, terminal count reloads the current address and count from the base copies, and the channel stays unmasked.
- R9: A channel in hand-off mode forwards its request while it is unmasked, but an acknowledge makes no bus cycle and leaves its address and count unchanged.
- R10: bus_to_mem is 1 for a cycle of a device-to-memory channel and 0 for a memory-to-device channel.
- R11: With word-wide channels, bus_addr carries the current address shifted left by one bit.
- R12: A write to port address 11 loads all mask bits from the low data bits, one bit per channel. A read of port address 11 returns the mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | AW (4) | Port register address |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after io_rd |
| dreq | input | NUM_CH | Per-channel device request |
| dack | input | NUM_CH | Per-channel acknowledge strobe, one per bus cycle |
| ch_req | output | NUM_CH | Requests forwarded from unmasked channels |
| tc_pulse | output | NUM_CH | One-cycle terminal-count pulse per channel |
| bus_valid | output | 1 | A bus cycle was made |
| bus_addr | output | 16+WORD_CH | Memory address of that cycle |
| bus_to_mem | output | 1 | 1 when the cycle moves data from the device into memory |

## Verification
The bench builds two instances that receive the same stimulus. The first has four byte-wide channels, and the second is identical except that its channels are word-wide. Comparing their bus_addr outputs shows the byte-address scaling on the same cycles. With four channels, one run can keep a plain channel, an auto-reload channel and a hand-off channel programmed side by side. That puts self-masking at terminal count, reload and mask-register readback all within reach, along with a deliberately desynchronised byte pointer that is then recovered with the clear command.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int REG_W  = 16;
  localparam int PORT_W = 8;

  typedef enum logic [1:0] {
    XFER_TO_MEM   = 2'b00,
    XFER_FROM_MEM = 2'b01,
    XFER_HANDOFF  = 2'b10,
    XFER_HANDOFF2 = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    CTL_MODE    = 2'd0,
    CTL_MASK1   = 2'd1,
    CTL_PTRCLR  = 2'd2,
    CTL_MASKALL = 2'd3
  } ctl_slot_e;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [NUM_CH-1:0] chan_sel,
  output logic              reg_is_cnt,
  output logic              hi_sel,
  output logic              chan_wr,
  output logic              chan_rd,
  output logic              mode_wr,
  output logic              mask1_wr,
  output logic              maskall_wr,
  output logic              status_rd,
  output logic              mask_rd
);
  logic            in_chan;
  logic [CH_W-1:0] ch_idx;
  ctl_slot_e       slot;
  logic            ptr_q;

  assign in_chan    = ~io_addr[AW-1];
  assign ch_idx     = io_addr[CH_W:1];
  assign slot       = ctl_slot_e'(io_addr[1:0]);
  assign reg_is_cnt = io_addr[0];
  assign hi_sel     = ptr_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign chan_sel[i] = in_chan && (ch_idx == CH_W'(i));
  end

  assign chan_wr    = io_wr && in_chan;
  assign chan_rd    = io_rd && in_chan;
  assign mode_wr    = io_wr && !in_chan && (slot == CTL_MODE);
  assign mask1_wr   = io_wr && !in_chan && (slot == CTL_MASK1);
  assign maskall_wr = io_wr && !in_chan && (slot == CTL_MASKALL);
  assign status_rd  = io_rd && !in_chan && (slot == CTL_MODE);
  assign mask_rd    = io_rd && !in_chan && (slot == CTL_MASKALL);

  // Shared byte pointer: cleared by command, flips on every channel access.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= 1'b0;
    end else if (io_wr && !in_chan && (slot == CTL_PTRCLR)) begin
      ptr_q <= 1'b0;
    end else if ((io_wr || io_rd) && in_chan) begin
      ptr_q <= ~ptr_q;
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_is_cnt,
  input  logic             reg_hi,
  input  logic [PORT_W-1:0] wdata,
  input  logic             mode_we,
  input  xfer_mode_e       mode_in,
  input  logic             auto_in,
  input  logic             mask_we,
  input  logic             mask_in,
  input  logic             ack,
  output logic [REG_W-1:0] cur_addr,
  output logic [REG_W-1:0] cur_cnt,
  output logic             masked,
  output logic             to_mem,
  output logic             advance,
  output logic             tc
);
  logic [REG_W-1:0] base_addr;
  logic [REG_W-1:0] base_cnt;
  xfer_mode_e       mode_q;
  logic             auto_q;

  assign masked  = mask_q_w;
  logic mask_q_w;

  assign to_mem  = ~mode_q[0];
  assign advance = ack && !mask_q_w && !mode_q[1];
  assign tc      = advance && (cur_cnt == REG_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode_q    <= XFER_TO_MEM;
      auto_q    <= 1'b0;
      mask_q_w  <= 1'b1;
    end else begin
      if (advance) begin
        if (tc && auto_q) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= cur_addr + REG_W'(1);
          cur_cnt  <= cur_cnt - REG_W'(1);
        end
        if (tc && !auto_q) mask_q_w <= 1'b1;
      end
      // A port write takes precedence over a step on the same byte.
      if (reg_we) begin
        if (reg_is_cnt) begin
          if (reg_hi) begin
            base_cnt[15:8] <= wdata;
            cur_cnt[15:8]  <= wdata;
          end else begin
            base_cnt[7:0]  <= wdata;
            cur_cnt[7:0]   <= wdata;
          end
        end else begin
          if (reg_hi) begin
            base_addr[15:8] <= wdata;
            cur_addr[15:8]  <= wdata;
          end else begin
            base_addr[7:0]  <= wdata;
            cur_addr[7:0]   <= wdata;
          end
        end
      end
      if (mode_we) begin
        mode_q <= mode_in;
        auto_q <= auto_in;
      end
      if (mask_we) mask_q_w <= mask_in;
    end
  end
endmodule

// File: rtl/dma_regs_front.sv
module dma_regs_front
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int WORD_CH = 0,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int AW     = CH_W + 2,
  localparam int BUS_AW = REG_W + WORD_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [NUM_CH-1:0] dreq,
  input  logic [NUM_CH-1:0] dack,
  output logic [NUM_CH-1:0] ch_req,
  output logic [NUM_CH-1:0] tc_pulse,
  output logic              bus_valid,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_to_mem
);
  logic [NUM_CH-1:0] chan_sel;
  logic reg_is_cnt, hi_sel, chan_wr, chan_rd;
  logic mode_wr, mask1_wr, maskall_wr, status_rd, mask_rd;

  logic [REG_W-1:0]  addr_a [NUM_CH];
  logic [REG_W-1:0]  cnt_a  [NUM_CH];
  logic [NUM_CH-1:0] mask_vec, to_mem_vec, adv_vec, tc_vec;
  logic [NUM_CH-1:0] tc_flags;
  logic [CH_W-1:0]   wsel;
  logic              unused_wdata;

  assign wsel         = io_wdata[CH_W-1:0];
  assign unused_wdata = ^io_wdata;

  dma_port_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW)) u_dec (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .chan_sel(chan_sel), .reg_is_cnt(reg_is_cnt), .hi_sel(hi_sel),
    .chan_wr(chan_wr), .chan_rd(chan_rd), .mode_wr(mode_wr),
    .mask1_wr(mask1_wr), .maskall_wr(maskall_wr), .status_rd(status_rd),
    .mask_rd(mask_rd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_hit;
    assign ch_hit = (wsel == CH_W'(i));
    dma_chan u_ch (
      .clk(clk), .rst(rst),
      .reg_we(chan_wr && chan_sel[i]), .reg_is_cnt(reg_is_cnt), .reg_hi(hi_sel),
      .wdata(io_wdata),
      .mode_we(mode_wr && ch_hit),
      .mode_in(xfer_mode_e'(io_wdata[CH_W+1:CH_W])),
      .auto_in(io_wdata[CH_W+2]),
      .mask_we((mask1_wr && ch_hit) || maskall_wr),
      .mask_in(maskall_wr ? io_wdata[i] : io_wdata[CH_W]),
      .ack(dack[i]),
      .cur_addr(addr_a[i]), .cur_cnt(cnt_a[i]), .masked(mask_vec[i]),
      .to_mem(to_mem_vec[i]), .advance(adv_vec[i]), .tc(tc_vec[i])
    );
  end

  // Read data mux
  logic [7:0]       rd_byte;
  logic [REG_W-1:0] pick;
  always_comb begin
    rd_byte = '0;
    pick    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_sel[i]) pick = reg_is_cnt ? cnt_a[i] : addr_a[i];
    end
    if (chan_rd)        rd_byte = hi_sel ? pick[15:8] : pick[7:0];
    else if (status_rd) rd_byte = 8'(tc_flags);
    else if (mask_rd)   rd_byte = 8'(mask_vec);
  end

  // Lowest acknowledged channel drives the bus outputs
  logic [REG_W-1:0]  sel_addr;
  logic              sel_dir;
  logic [BUS_AW-1:0] scaled;
  always_comb begin
    sel_addr = '0;
    sel_dir  = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (adv_vec[i]) begin
        sel_addr = addr_a[i];
        sel_dir  = to_mem_vec[i];
      end
    end
  end

  if (WORD_CH != 0) begin : g_word
    assign scaled = {sel_addr, 1'b0};
  end else begin : g_byte
    assign scaled = sel_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata   <= '0;
      tc_flags   <= '0;
      tc_pulse   <= '0;
      ch_req     <= '0;
      bus_valid  <= 1'b0;
      bus_addr   <= '0;
      bus_to_mem <= 1'b0;
    end else begin
      if (io_rd) io_rdata <= rd_byte;
      if (status_rd) tc_flags <= tc_vec;
      else           tc_flags <= tc_flags | tc_vec;
      tc_pulse  <= tc_vec;
      ch_req    <= dreq & ~mask_vec;
      bus_valid <= |adv_vec;
      if (|adv_vec) begin
        bus_addr   <= scaled;
        bus_to_mem <= sel_dir;
      end
    end
  end
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] dreq,
  input logic [NUM_CH-1:0] dack,
  input logic [NUM_CH-1:0] ch_req,
  input logic [NUM_CH-1:0] tc_pulse,
  input logic              bus_valid,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] tc_flags,
  input logic [7:0]        io_rdata
);
  logic rst_q = 1'b0;
  always @(posedge clk) rst_q <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_q && !rst) begin
      reset_state_chk: assert (mask_q == '1 && io_rdata == 8'h00 && tc_flags == '0);
    end
  end

  // R5
  req_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_req & ~$past(dreq)) == '0);

  // R6
  bus_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> $past(|dack));

  // R7
  tc_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse & ~tc_flags) == '0);

  // R7
  tc_with_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse != '0) |-> bus_valid);
endmodule

bind dma_regs_front dma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .dreq(dreq), .dack(dack), .ch_req(ch_req),
  .tc_pulse(tc_pulse), .bus_valid(bus_valid), .mask_q(mask_vec),
  .tc_flags(tc_flags), .io_rdata(io_rdata)
);

// File: tb/sim_dma_regs_front.sv
module sim_dma_regs_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [3:0] dreq = '0;
  logic [3:0] dack = '0;

  logic [7:0]  rdata0, rdata1;
  logic [3:0]  req0, req1, tcp0, tcp1;
  logic        bv0, bv1, dir0, dir1;
  logic [15:0] baddr0;
  logic [16:0] baddr1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_regs_front #(.NUM_CH(4), .WORD_CH(0)) u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata0), .dreq(dreq), .dack(dack),
    .ch_req(req0), .tc_pulse(tcp0), .bus_valid(bv0), .bus_addr(baddr0),
    .bus_to_mem(dir0)
  );

  dma_regs_front #(.NUM_CH(4), .WORD_CH(1)) u1 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata1), .dreq(dreq), .dack(dack),
    .ch_req(req1), .tc_pulse(tcp1), .bus_valid(bv1), .bus_addr(baddr1),
    .bus_to_mem(dir1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = rdata0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a, v[7:0]);
    wr(a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic ptr_clear();
    wr(4'd10, 8'h00);
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    dack = 4'(1 << ch);
    @(negedge clk);
    dack = '0;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    check("R1 rdata after reset", rdata0, 8'h00);
    check("R1 bus_valid after reset", bv0, 1'b0);
    dreq = 4'hF;
    @(negedge clk);
    @(negedge clk);
    check("R1 R5 requests blocked while masked", req0, 4'h0);
    dreq = 4'h0;
    rd(4'd11, b);
    check("R1 all channels masked", b, 8'h0F);
    rd(4'd8, b);
    check("R1 status clear", b, 8'h00);
  endtask

  task automatic t_pointer();
    logic [15:0] v;
    ptr_clear();
    wr16(4'd0, 16'h1234);
    rd16(4'd0, v);
    check("R2 R4 address low/high pair", v, 16'h1234);
    wr(4'd1, 8'h05);
    wr(4'd1, 8'hAA);
    rd16(4'd1, v);
    check("R2 pointer toggles across single writes", v, 16'hAA05);
    wr(4'd0, 8'h77);
    ptr_clear();
    wr(4'd0, 8'h66);
    ptr_clear();
    rd16(4'd0, v);
    check("R3 clear command resynchronises pointer", v, 16'h1266);
  endtask

  task automatic t_advance();
    logic [15:0] v;
    logic [7:0]  b;
    ptr_clear();
    wr16(4'd2, 16'h0100);
    wr16(4'd3, 16'd3);
    wr(4'd8, 8'h01);
    ack(1);
    check("R5 masked channel no bus cycle", bv0, 1'b0);
    rd16(4'd2, v);
    check("R5 masked channel address unchanged", v, 16'h0100);
    wr(4'd9, 8'h01);
    rd(4'd11, b);
    check("R5 R12 single unmask", b, 8'h0D);
    dreq = 4'b0010;
    @(negedge clk);
    @(negedge clk);
    check("R5 unmasked request forwarded", req0, 4'b0010);
    dreq = '0;
    ack(1);
    check("R6 bus_valid", bv0, 1'b1);
    check("R6 bus_addr before step", baddr0, 16'h0100);
    check("R10 device-to-memory direction", dir0, 1'b1);
    check("R11 word channel byte address", baddr1, 17'h00200);
    check("R6 no tc mid transfer", tcp0, 4'h0);
    @(negedge clk);
    check("R6 bus_valid one cycle", bv0, 1'b0);
    rd16(4'd2, v);
    check("R4 R6 address incremented", v, 16'h0101);
    rd16(4'd3, v);
    check("R6 count decremented", v, 16'd2);
    wr(4'd8, 8'h05);
    ack(1);
    check("R10 memory-to-device direction", dir0, 1'b0);
    check("R6 second address", baddr0, 16'h0101);
  endtask

  task automatic t_terminal();
    logic [15:0] v;
    logic [7:0]  b;
    ack(1);
    check("R7 tc pulse", tcp0, 4'b0010);
    @(negedge clk);
    check("R7 tc pulse one cycle", tcp0, 4'b0000);
    rd(4'd11, b);
    check("R7 channel self-masks", b, 8'h0F);
    ptr_clear();
    rd16(4'd3, v);
    check("R7 residue zero", v, 16'd0);
    rd(4'd8, b);
    check("R7 status bit", b, 8'h02);
    rd(4'd8, b);
    check("R7 status cleared by read", b, 8'h00);
    ack(1);
    check("R7 no cycle after terminal count", bv0, 1'b0);
    ptr_clear();
    rd16(4'd2, v);
    check("R7 address stops", v, 16'h0103);
  endtask

  task automatic t_autoreload();
    logic [15:0] v;
    logic [7:0]  b;
    ptr_clear();
    wr16(4'd4, 16'h0500);
    wr16(4'd5, 16'd2);
    wr(4'd8, 8'h12);
    wr(4'd9, 8'h02);
    ack(2);
    check("R8 first cycle no tc", tcp0, 4'h0);
    ack(2);
    check("R8 tc on reload channel", tcp0, 4'b0100);
    check("R8 last address on bus", baddr0, 16'h0501);
    rd16(4'd4, v);
    check("R8 address reloaded", v, 16'h0500);
    rd16(4'd5, v);
    check("R8 count reloaded", v, 16'd2);
    rd(4'd11, b);
    check("R8 channel stays unmasked", b, 8'h0B);
    rd(4'd8, b);
    check("R8 status bit", b, 8'h04);
  endtask

  task automatic t_handoff();
    logic [15:0] v;
    logic [7:0]  b;
    ptr_clear();
    wr16(4'd6, 16'h0700);
    wr16(4'd7, 16'd5);
    wr(4'd8, 8'h0B);
    wr(4'd11, 8'h00);
    rd(4'd11, b);
    check("R12 mask-all clear", b, 8'h00);
    dreq = 4'b1000;
    @(negedge clk);
    @(negedge clk);
    check("R9 hand-off request forwarded", req0, 4'b1000);
    dreq = '0;
    ack(3);
    check("R9 hand-off makes no cycle", bv0, 1'b0);
    rd16(4'd6, v);
    check("R9 hand-off address unchanged", v, 16'h0700);
    rd16(4'd7, v);
    check("R9 hand-off count unchanged", v, 16'd5);
    wr(4'd11, 8'h0F);
    rd(4'd11, b);
    check("R12 mask-all set", b, 8'h0F);
    dreq = 4'b1000;
    @(negedge clk);
    @(negedge clk);
    check("R12 R5 request blocked after mask-all", req0, 4'b0000);
    dreq = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_advance();
    t_terminal();
    t_autoreload();
    t_handoff();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule